// File: doc/BRIEF.md
# Synchronous Serial Master Shifter

This block is the master side of a three-wire synchronous serial link: a serial clock, a data-out line and a data-in line. When the host writes a byte into the transmit buffer, the block drives eight clock periods. It shifts the byte out on the data-out line and, in the same transfer, shifts a byte in from the data-in line. At the end it presents the received byte with a one-cycle completion strobe.

Two configuration bits select one of four clocking schemes:

- **Clock polarity** sets the idle level of the serial clock.
- **Clock phase** decides which edges sample the input and which edges move the output to the next bit.

A third bit selects whether the most or the least significant bit travels first. A half-period count sets the bit rate in system clocks; a value of zero counts as one. Between transfers the data-out line rests high, and it is also high from reset.

The mode, order and rate inputs are captured when a transfer starts. A write that arrives while a transfer is running is dropped.

Top module: `sync_serial_master`

## Requirements
- R1: After reset and whenever no transfer runs, `busy` is 0, `rx_valid` is 0, `sdo` is 1, `rx_data` is 0 until the first completion, and `sclk` equals `cfg_cpol`.
- R2: A system clock edge with `wr_en`=1 and `busy`=0 starts a transfer, and `busy` reads 1 from the next cycle on. With H = max(`cfg_half_div`,1) sampled at that edge, `busy` stays 1 for exactly 16·H cycles.
- R3: During a transfer, `sclk` starts at the captured polarity level and toggles exactly 16 times, once every H system clocks. It ends on the idle level.
- R4: With `cfg_cpha`=0, `sdo` shows the first bit from the cycle after the write. Each odd-numbered clock edge (1st, 3rd, …) samples `sdi`. Each even-numbered edge except the 16th moves `sdo` to the next bit.
- R5: With `cfg_cpha`=1, `sdo` stays 1 until the 1st clock edge, which drives the first bit. Edges 3, 5, …, 15 move to the next bit, and every even-numbered edge samples `sdi`.
- R6: `cfg_lsb_first`=0 sends `wr_data` bit 7 first and places the first received bit at `rx_data` bit 7. `cfg_lsb_first`=1 sends bit 0 first and places the first received bit at bit 0.
- R7: On the cycle after the 16th clock edge:
  - `busy` is 0 and `sdo` is 1.
  - `rx_valid` is 1 for exactly one cycle.
  - `rx_data` holds the assembled byte, and keeps it until the next completion.
- R8: A write (`wr_en`=1) while `busy`=1 is ignored: the running transfer's output bits, clock and received byte are unchanged.
- R9: Changes to `cfg_cpol`, `cfg_cpha`, `cfg_lsb_first` and `cfg_half_div` during a transfer do not affect that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase: 0 = sample on leading edge, 1 = sample on trailing edge |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_half_div | input | DIV_W | Serial clock half-period in system clocks (0 acts as 1) |
| wr_en | input | 1 | Transmit buffer write strobe |
| wr_data | input | DATA_W | Byte to transmit |
| busy | output | 1 | Transfer in progress |
| rx_valid | output | 1 | One-cycle completion strobe |
| rx_data | output | DATA_W | Last received byte |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
A stale edge counter or divider shows at once on `sclk`: a toggle lands one system clock early or late, or an extra or missing toggle moves the fall of `busy` off the 16·H mark. A wrong shift register or phase decode shows on `sdo` within one half-period of the faulty edge. A wrong receive shift or order shows only when `rx_valid` rises, so every transfer checks `rx_data` against the byte the bench slave sent. Writes injected mid-transfer and configuration changes mid-transfer show any leak of new state into the running transfer as a changed bit on `sdo` or a mistimed clock edge.

// File: rtl/sync_serial_master.sv
module sync_serial_master #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic [DIV_W-1:0]  cfg_half_div,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk,
  output logic              sdo,
  input  logic              sdi
);
  localparam int EDGES  = 2 * DATA_W;
  localparam int ECNT_W = $clog2(EDGES + 1);

  logic              busy_q, tog_q, drv_q, rxv_q;
  logic              cpol_q, cpha_q, lsb_q;
  logic [DIV_W-1:0]  half_q, div_q;
  logic [ECNT_W-1:0] edge_q;
  logic [DATA_W-1:0] tx_q, rx_q, rxd_q;

  wire start     = wr_en & ~busy_q;
  wire tick      = busy_q & (div_q == half_q - 1'b1);
  wire lead      = ~edge_q[0];
  wire last      = edge_q == ECNT_W'(EDGES - 1);
  wire do_sample = tick & (lead ^ cpha_q);
  wire do_shift  = tick & (lead == cpha_q) & (edge_q != '0) & ~last;
  wire do_drive  = tick & cpha_q & (edge_q == '0);
  wire tx_bit    = lsb_q ? tx_q[0] : tx_q[DATA_W-1];

  wire [DATA_W-1:0] rx_next = lsb_q ? {sdi, rx_q[DATA_W-1:1]}
                                    : {rx_q[DATA_W-2:0], sdi};
  wire [DATA_W-1:0] tx_next = lsb_q ? (tx_q >> 1) : (tx_q << 1);

  assign busy     = busy_q;
  assign rx_valid = rxv_q;
  assign rx_data  = rxd_q;
  assign sclk     = busy_q ? (cpol_q ^ tog_q) : cfg_cpol;
  assign sdo      = (busy_q & drv_q) ? tx_bit : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tog_q  <= 1'b0;
      drv_q  <= 1'b0;
      rxv_q  <= 1'b0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      lsb_q  <= 1'b0;
      half_q <= DIV_W'(1);
      div_q  <= '0;
      edge_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      rxd_q  <= '0;
    end else begin
      rxv_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        tog_q  <= 1'b0;
        drv_q  <= ~cfg_cpha;
        cpol_q <= cfg_cpol;
        cpha_q <= cfg_cpha;
        lsb_q  <= cfg_lsb_first;
        half_q <= (cfg_half_div == '0) ? DIV_W'(1) : cfg_half_div;
        div_q  <= '0;
        edge_q <= '0;
        tx_q   <= wr_data;
      end else if (busy_q) begin
        if (tick) begin
          div_q  <= '0;
          tog_q  <= ~tog_q;
          edge_q <= edge_q + 1'b1;
          if (do_sample) rx_q <= rx_next;
          if (do_shift)  tx_q <= tx_next;
          if (do_drive)  drv_q <= 1'b1;
          if (last) begin
            busy_q <= 1'b0;
            drv_q  <= 1'b0;
            rxv_q  <= 1'b1;
            rxd_q  <= cpha_q ? rx_next : rx_q;
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end
endmodule

module sync_serial_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_cpha,
  input logic wr_en,
  input logic busy,
  input logic rx_valid,
  input logic sdo
);
  a_r2_write_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy) |=> busy);

  a_r1_idle_sdo_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> sdo);

  a_r5_cpha1_holds_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(cfg_cpha)) |-> sdo);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r7_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (rx_valid && sdo));

  a_r7_valid_needs_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (!busy && $past(busy)));
endmodule

bind sync_serial_master sync_serial_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cpha(cfg_cpha), .wr_en(wr_en),
  .busy(busy), .rx_valid(rx_valid), .sdo(sdo)
);

// File: tb/sync_serial_master_tb.sv
module sync_serial_master_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_cpol = 1'b1, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
  logic [7:0] cfg_half_div = 8'd1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       sdi = 1'b1;
  logic       busy, rx_valid, sclk, sdo;
  logic [7:0] rx_data;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_serial_master u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .cfg_half_div(cfg_half_div),
    .wr_en(wr_en), .wr_data(wr_data), .busy(busy), .rx_valid(rx_valid),
    .rx_data(rx_data), .sclk(sclk), .sdo(sdo), .sdi(sdi)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic bit_of(input logic [7:0] d, input int j, input bit lsb);
    return lsb ? d[j] : d[7-j];
  endfunction

  // Starts and ends on a falling clock edge.
  task automatic xfer(input bit pol, input bit pha, input bit lsb, input int h,
                      input logic [7:0] tx, input logic [7:0] sl,
                      input bit poke, input bit scramble);
    int heff = (h == 0) ? 1 : h;
    logic lvl = pol;
    string rp = pha ? "R5" : "R4";
    cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb; cfg_half_div = 8'(h);
    wr_en = 1'b1; wr_data = tx;
    sdi = pha ? 1'b1 : bit_of(sl, 0, lsb);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R2", "busy after write", busy, 1);
    chk("R3", "sclk at start", sclk, pol);
    chk(rp, "sdo at start", sdo, pha ? 1'b1 : bit_of(tx, 0, lsb));
    if (scramble) begin
      cfg_cpol = ~pol; cfg_cpha = ~pha; cfg_lsb_first = ~lsb; cfg_half_div = 8'd7;
    end
    for (int k = 1; k <= 16; k++) begin
      for (int w = 0; w < heff - 1; w++) begin
        @(negedge clk);
        wr_en = 1'b0;
        chk("R3", "sclk held within half period", sclk, lvl);
        chk("R2", "busy mid transfer", busy, 1);
      end
      @(negedge clk);
      wr_en = 1'b0;
      lvl = ~lvl;
      chk(scramble ? "R9" : "R3", "sclk after edge", sclk, lvl);
      if (k < 16) begin
        chk("R2", "busy before end", busy, 1);
        chk("R7", "no early valid", rx_valid, 0);
        chk(poke ? "R8" : (lsb ? "R6" : rp), "sdo bit", sdo,
            pha ? bit_of(tx, (k-1)/2, lsb) : bit_of(tx, k/2, lsb));
        if (!pha && (k % 2 == 0)) sdi = bit_of(sl, k/2, lsb);
        if (pha && (k % 2 == 1))  sdi = bit_of(sl, (k-1)/2, lsb);
        if (poke && k == 4) begin
          wr_en = 1'b1; wr_data = ~tx;
        end
        if (scramble && k == 15) begin
          cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb; cfg_half_div = 8'(h);
        end
      end else begin
        chk("R2", "busy cleared after 16 edges", busy, 0);
        chk("R7", "rx_valid pulse", rx_valid, 1);
        chk(lsb ? "R6" : "R7", "rx_data", rx_data, sl);
        chk("R7", "sdo high at end", sdo, 1);
      end
    end
    @(negedge clk);
    chk("R7", "rx_valid one cycle", rx_valid, 0);
    chk("R7", "rx_data held", rx_data, sl);
    chk("R1", "sdo idle", sdo, 1);
    chk("R1", "sclk idle", sclk, pol);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "sclk in reset", sclk, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "rx_valid after reset", rx_valid, 0);
    chk("R1", "sdo after reset", sdo, 1);
    chk("R1", "rx_data after reset", rx_data, 0);
    chk("R1", "sclk idle follows polarity", sclk, 1);
    cfg_cpol = 1'b0;
    @(negedge clk);
    chk("R1", "sclk idle follows polarity", sclk, 0);

    for (int m = 0; m < 4; m++)
      xfer(m[1], m[0], 1'b0, 1, 8'hA5, 8'h3C, 1'b0, 1'b0);
    for (int m = 0; m < 4; m++)
      xfer(m[1], m[0], 1'b1, 2, 8'h81, 8'h17, 1'b0, 1'b0);
    xfer(1'b0, 1'b0, 1'b0, 0, 8'h00, 8'hFF, 1'b0, 1'b0);
    xfer(1'b1, 1'b1, 1'b1, 3, 8'hFF, 8'h00, 1'b0, 1'b0);
    xfer(1'b0, 1'b1, 1'b0, 2, 8'h5A, 8'hC3, 1'b1, 1'b0);
    xfer(1'b1, 1'b0, 1'b1, 1, 8'h96, 8'h69, 1'b1, 1'b0);
    xfer(1'b0, 1'b0, 1'b0, 2, 8'h4E, 8'hB1, 1'b0, 1'b1);
    xfer(1'b1, 1'b1, 1'b1, 1, 8'h2D, 8'hD2, 1'b1, 1'b1);

    for (int i = 0; i < 40; i++) begin
      logic [31:0] r = $urandom;
      xfer(r[0], r[1], r[2], int'(r[4:3]) + 1, 8'($urandom), 8'($urandom),
           r[5], r[6]);
      if (r[7]) repeat (int'(r[9:8])) @(negedge clk);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule